// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block is the address side of one DMA channel. Software loads a start address, a packed configuration word, and count and step values for an inner loop (X, one row) and an outer loop (Y, the rows). The channel then hands out one memory byte address per element. Each element goes through a request/acknowledge handshake. An element is consumed in any cycle where the request and the acknowledge are both high. The data movement itself happens elsewhere.

The channel walks a row by adding a signed X step after each element. After the last element of a row it adds a signed Y step instead. This lets contiguous, strided or backwards layouts be described. There is a one-dimensional mode, where the outer loop is a single row. The flow field picks one of two ways to finish:
- **Stop mode:** the channel parks after the final element.
- **Auto-buffer mode:** the channel reloads the start address and both counts and carries on with no software action.

A sticky data-interrupt flag can be set at the end of each row or only at the end of the whole buffer. A sticky error flag records an attempt to start with a zero count. Both flags are cleared by writing ones to the status selector.

Top module: `dma2d_addr_gen`

## Requirements
- R1: Config word fields:
  - bit 0: enable.
  - bit 1: direction, driven on `elem_wnr` (1 = write to memory).
  - bits 3:2: element width, driven on `elem_size` (00 = 8-bit, 01 = 16-bit, 10 = 32-bit).
  - bit 4: 2D mode.
  - bit 6: interrupt timing (1 = every row end, 0 = buffer end only).
  - bit 7: data interrupt enable.
  - bits 15:12: flow (0 = stop, 1 = auto-buffer).
  - Example: 0x10D7 decodes to auto-buffer, interrupt on, per-row, 2D, 16-bit, memory write, enabled. 0x101B decodes to auto-buffer, interrupt off, 2D, 32-bit, memory write, enabled.
- R2: Starting a session:
  - A write of the config word (selector 1) with bit 0 set and nonzero counts starts a session at the next edge.
  - `cur_addr` takes the start address and `cur_xcnt` takes the X count.
  - `cur_ycnt` takes the Y count in 2D mode, or 1 in 1D mode.
  - `elem_req` goes high.
- R3: Each accepted element that is not last in its row adds the signed X step to `cur_addr`, modulo 2^ADDR_W. It also lowers `cur_xcnt` by one.
- R4: The last element of a row that is not the last row adds the signed Y step to `cur_addr`. It also reloads `cur_xcnt` from the X count and lowers `cur_ycnt` by one.
- R5: In stop mode, the last element of the last row clears the running state and drops `elem_req`. The enable bit stays set and the address and counts keep their values.
- R6: In auto-buffer mode, the last element of the last row reloads the start address and both counts. The request stays high.
- R7: With interrupt enable set, the data interrupt flag sets at each row end when per-row timing is selected, and otherwise at the buffer end only. With interrupt enable clear it never sets. `data_irq` shows the flag.
- R8: Writing the status selector (6) with bit 0 set clears the data interrupt flag. This has no effect on a running transfer.
- R9: Error on a zero count:
  - Cause: a start (R2) with an X count of zero, or with a Y count of zero in 2D mode.
  - Effect: sets the error flag and leaves the channel not running.
  - Clearing: writing the status selector with bit 1 set clears the error flag.
- R10: `status` encoding:
  - bit 0: data interrupt flag.
  - bit 1: error flag.
  - bit 2: running.
  - bit 3: enabled.
  - This gives disabled (bit 3 low), enabled-but-stopped (bits 3:2 = 10) or enabled-and-running (11). All bits are zero after reset.
- R11: A config write with bit 0 clear stops the channel at the next edge.
- R12: While `elem_req` is high and `elem_ack` is low, the address and counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector: 0 start, 1 config, 2 X count, 3 X step, 4 Y count, 5 Y step, 6 status clear |
| reg_wdata | input | 32 | Register write data |
| elem_req | output | 1 | Element request (channel running) |
| elem_ack | input | 1 | Element accepted by the data mover |
| elem_wnr | output | 1 | Direction of the transfer, 1 = memory write |
| elem_size | output | 2 | Element width code |
| cur_addr | output | ADDR_W | Current element byte address |
| cur_xcnt | output | CNT_W | Elements left in the current row |
| cur_ycnt | output | CNT_W | Rows left, including the current one |
| status | output | 4 | Status word (R10) |
| data_irq | output | 1 | Data interrupt flag |

## Verification
The bench builds the block with ADDR_W = 20 and CNT_W = 10. With these values a 512-element row fits in the count registers. They also let a negative Y step from a low start address wrap past zero, which shows that the address arithmetic is modulo 2^ADDR_W. Both given configurations are run to their wrap points. So are a backwards 1D stop transfer and a 2D stop transfer with a negative Y step. Throughout, a behavioural model checks the address, both counts, the status word and the handshake every clock, under continuous, alternating and irregular acknowledge patterns.

// File: rtl/dma2d_pkg.sv
// Package: shared selector codes and the config word layout for the
// two-dimensional DMA address sequencer.
package dma2d_pkg;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_CFG   = 3'd1,
        SEL_XCNT  = 3'd2,
        SEL_XSTEP = 3'd3,
        SEL_YCNT  = 3'd4,
        SEL_YSTEP = 3'd5,
        SEL_STAT  = 3'd6
    } reg_sel_e;

    localparam int CFG_W = 16;
    localparam logic [3:0] FLOW_STOP = 4'd0;
    localparam logic [3:0] FLOW_AUTO = 4'd1;

    // Config word, most significant field first.
    typedef struct packed {
        logic [3:0] flow;      // 15:12
        logic [3:0] rsv_hi;    // 11:8
        logic       irq_en;    // 7
        logic       irq_row;   // 6
        logic       rsv5;      // 5
        logic       two_d;     // 4
        logic [1:0] size;      // 3:2
        logic       wnr;       // 1
        logic       en;        // 0
    } cfg_t;

    localparam int N_FLAGS  = 2;
    localparam int FLAG_IRQ = 0;
    localparam int FLAG_ERR = 1;

endpackage

// File: rtl/dma2d_regs.sv
// Module: dma2d_regs
// Holds the software-written parameters (start address, config, counts,
// steps) and the two sticky flags (data interrupt, error).
// Assumes: the walker reports row/buffer ends and errors as one-cycle
// pulses; a flag set and its clear in the same cycle leaves the flag set.
module dma2d_regs
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              row_end,
    input  logic              buf_end,
    input  logic              err_evt,
    output logic [ADDR_W-1:0] start_addr,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  xcnt,
    output logic [ADDR_W-1:0] xstep,
    output logic [CNT_W-1:0]  ycnt,
    output logic [ADDR_W-1:0] ystep,
    output logic [N_FLAGS-1:0] flags
);

    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic               stat_wr;

    // Parameter register writes.
    always_ff @(posedge clk) begin : param_regs
        if (!rst_n) begin
            start_addr <= '0;
            cfg        <= '0;
            xcnt       <= '0;
            xstep      <= '0;
            ycnt       <= '0;
            ystep      <= '0;
        end else if (we) begin
            case (reg_sel_e'(sel))
                SEL_START: start_addr <= wdata[ADDR_W-1:0];
                SEL_CFG:   cfg        <= cfg_t'(wdata[CFG_W-1:0]);
                SEL_XCNT:  xcnt       <= wdata[CNT_W-1:0];
                SEL_XSTEP: xstep      <= wdata[ADDR_W-1:0];
                SEL_YCNT:  ycnt       <= wdata[CNT_W-1:0];
                SEL_YSTEP: ystep      <= wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // Set and clear requests for each sticky flag.
    always_comb begin : flag_reqs
        stat_wr            = we && (sel == SEL_STAT);
        flag_set[FLAG_IRQ] = cfg.irq_en && (cfg.irq_row ? row_end : buf_end);
        flag_set[FLAG_ERR] = err_evt;
        flag_clr           = stat_wr ? wdata[N_FLAGS-1:0] : '0;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // One sticky, write-one-to-clear flag; a set wins over a clear.
        always_ff @(posedge clk) begin : flag_cell
            if (!rst_n)           flags[g] <= 1'b0;
            else if (flag_set[g]) flags[g] <= 1'b1;
            else if (flag_clr[g]) flags[g] <= 1'b0;
        end
    end

    // A flag stays set until software clears it (R8).
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_IRQ] && !flag_clr[FLAG_IRQ] |=> flags[FLAG_IRQ]);

    // An error report always leaves the error flag set (R9).
    assert_err_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> flags[FLAG_ERR]);

endmodule

// File: rtl/dma2d_walker.sv
// Module: dma2d_walker
// Steps the current address and the X/Y counters once per accepted
// element. It starts, halts, and either parks (stop mode) or reloads
// (auto-buffer mode) at the end of the buffer.
// Assumes: launch and halt are one-cycle strobes from the config write;
// they take priority over an element acknowledge in the same cycle.
module dma2d_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_2d,
    input  logic              halt,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  xcnt,
    input  logic [ADDR_W-1:0] xstep,
    input  logic [CNT_W-1:0]  ycnt,
    input  logic [ADDR_W-1:0] ystep,
    input  logic              cfg_2d,
    input  logic              cfg_auto,
    input  logic              ack,
    output logic              running,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_x,
    output logic [CNT_W-1:0]  cur_y,
    output logic              row_end,
    output logic              buf_end,
    output logic              err_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic last_in_row;
    logic last_row;
    logic zero_cnt;

    // Decode this cycle's element events.
    always_comb begin : evt_decode
        step        = running && ack && !launch && !halt;
        last_in_row = (cur_x == ONE);
        last_row    = (cur_y == ONE);
        row_end     = step && last_in_row;
        buf_end     = row_end && last_row;
        zero_cnt    = (xcnt == '0) || (launch_2d && (ycnt == '0));
        err_evt     = launch && zero_cnt;
    end

    // Address and counter sequencing.
    always_ff @(posedge clk) begin : walk_seq
        if (!rst_n) begin
            running  <= 1'b0;
            cur_addr <= '0;
            cur_x    <= '0;
            cur_y    <= '0;
        end else if (launch) begin
            if (zero_cnt) begin
                running <= 1'b0;
            end else begin
                running  <= 1'b1;
                cur_addr <= start_addr;
                cur_x    <= xcnt;
                cur_y    <= launch_2d ? ycnt : ONE;
            end
        end else if (halt) begin
            running <= 1'b0;
        end else if (step) begin
            if (!last_in_row) begin
                cur_addr <= cur_addr + xstep;
                cur_x    <= cur_x - ONE;
            end else if (!last_row) begin
                cur_addr <= cur_addr + ystep;
                cur_x    <= xcnt;
                cur_y    <= cur_y - ONE;
            end else if (cfg_auto) begin
                cur_addr <= start_addr;
                cur_x    <= xcnt;
                cur_y    <= cfg_2d ? ycnt : ONE;
            end else begin
                running <= 1'b0;
            end
        end
    end

    // A valid launch starts at the start address (R2).
    assert_launch_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !zero_cnt |=> running && cur_addr == $past(start_addr));

    // The X counter never reaches zero while running (R3).
    assert_xcnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cur_x != '0);

    // A zero-count launch leaves the channel idle (R9).
    assert_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> !running);

    // A halt stops the channel (R11).
    assert_halt_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !launch |=> !running);

    // No acknowledge, no movement (R12).
    assert_hold_no_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        running && !ack && !launch && !halt |=>
            $stable(cur_addr) && $stable(cur_x) && $stable(cur_y) && running);

endmodule

// File: rtl/dma2d_addr_gen.sv
// Module: dma2d_addr_gen (top)
// One DMA channel's address sequencer: register write port, the
// element request/acknowledge handshake, current address and counts,
// status word and data interrupt.
// Assumes: an element is consumed when elem_req and elem_ack are both
// high at a clock edge.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              elem_req,
    input  logic              elem_ack,
    output logic              elem_wnr,
    output logic [1:0]        elem_size,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_xcnt,
    output logic [CNT_W-1:0]  cur_ycnt,
    output logic [3:0]        status,
    output logic              data_irq
);

    cfg_t               cfg_q;
    cfg_t               cfg_new;
    logic [ADDR_W-1:0]  start_addr;
    logic [CNT_W-1:0]   xcnt;
    logic [CNT_W-1:0]   ycnt;
    logic [ADDR_W-1:0]  xstep;
    logic [ADDR_W-1:0]  ystep;
    logic [N_FLAGS-1:0] flags;
    logic               cfg_wr;
    logic               launch;
    logic               halt;
    logic               running;
    logic               row_end;
    logic               buf_end;
    logic               err_evt;

    // Decode a config write into launch / halt strobes.
    always_comb begin : cfg_strobe
        cfg_new = cfg_t'(reg_wdata[CFG_W-1:0]);
        cfg_wr  = reg_we && (reg_sel == SEL_CFG);
        launch  = cfg_wr && cfg_new.en;
        halt    = cfg_wr && !cfg_new.en;
    end

    dma2d_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .row_end    (row_end),
        .buf_end    (buf_end),
        .err_evt    (err_evt),
        .start_addr (start_addr),
        .cfg        (cfg_q),
        .xcnt       (xcnt),
        .xstep      (xstep),
        .ycnt       (ycnt),
        .ystep      (ystep),
        .flags      (flags)
    );

    dma2d_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_2d  (cfg_new.two_d),
        .halt       (halt),
        .start_addr (start_addr),
        .xcnt       (xcnt),
        .xstep      (xstep),
        .ycnt       (ycnt),
        .ystep      (ystep),
        .cfg_2d     (cfg_q.two_d),
        .cfg_auto   (cfg_q.flow == FLOW_AUTO),
        .ack        (elem_ack),
        .running    (running),
        .cur_addr   (cur_addr),
        .cur_x      (cur_xcnt),
        .cur_y      (cur_ycnt),
        .row_end    (row_end),
        .buf_end    (buf_end),
        .err_evt    (err_evt)
    );

    // Output and status assembly.
    always_comb begin : out_map
        elem_req  = running;
        elem_wnr  = cfg_q.wnr;
        elem_size = cfg_q.size;
        data_irq  = flags[FLAG_IRQ];
        status    = {cfg_q.en, running, flags[FLAG_ERR], flags[FLAG_IRQ]};
    end

    // The channel only runs while enabled (R10).
    assert_run_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[3]);

    // Stop mode parks after the final element (R5).
    assert_stop_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_end && cfg_q.flow == FLOW_STOP && !reg_we |=> !elem_req && status[3]);

endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
// Bench: behavioural reference model compared with the DUT on every clock.
module dma2d_addr_gen_tb_top;

    localparam int AW   = 20;
    localparam int CW   = 10;
    localparam int AMSK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic          elem_ack = 1'b0;
    logic          elem_req;
    logic          elem_wnr;
    logic [1:0]    elem_size;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_xcnt;
    logic [CW-1:0] cur_ycnt;
    logic [3:0]    status;
    logic          data_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int ack_mode = 0;
    int lfsr = 32'h1d3;

    // Reference model state.
    int m_run, m_addr, m_x, m_y, m_irq, m_err;
    int r_start, r_cfg, r_xc, r_xm, r_yc, r_ym;

    always #2 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .elem_req(elem_req), .elem_ack(elem_ack),
        .elem_wnr(elem_wnr), .elem_size(elem_size), .cur_addr(cur_addr),
        .cur_xcnt(cur_xcnt), .cur_ycnt(cur_ycnt), .status(status),
        .data_irq(data_irq)
    );

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_addr = 0; m_x = 0; m_y = 0; m_irq = 0; m_err = 0;
            r_start = 0; r_cfg = 0; r_xc = 0; r_xm = 0; r_yc = 0; r_ym = 0;
        end else begin
            int wd, rowe, bufe, errs;
            wd = int'(reg_wdata);
            rowe = 0; bufe = 0; errs = 0;
            if (reg_we && reg_sel == 1 && wd[0]) begin
                if (r_xc == 0 || (wd[4] && r_yc == 0)) begin
                    errs = 1; m_run = 0;
                end else begin
                    m_run = 1; m_addr = r_start; m_x = r_xc;
                    m_y = wd[4] ? r_yc : 1;
                end
            end else if (reg_we && reg_sel == 1) begin
                m_run = 0;
            end else if (m_run != 0 && elem_ack) begin
                if (m_x > 1) begin
                    m_addr = (m_addr + r_xm) & AMSK; m_x--;
                end else begin
                    rowe = 1;
                    if (m_y > 1) begin
                        m_addr = (m_addr + r_ym) & AMSK; m_x = r_xc; m_y--;
                    end else begin
                        bufe = 1;
                        if (((r_cfg >> 12) & 15) == 1) begin
                            m_addr = r_start; m_x = r_xc;
                            m_y = r_cfg[4] ? r_yc : 1;
                        end else m_run = 0;
                    end
                end
            end
            if (r_cfg[7] && (r_cfg[6] ? rowe : bufe)) m_irq = 1;
            else if (reg_we && reg_sel == 6 && wd[0]) m_irq = 0;
            if (errs) m_err = 1;
            else if (reg_we && reg_sel == 6 && wd[1]) m_err = 0;
            if (reg_we) case (reg_sel)
                0: r_start = wd & AMSK;
                1: r_cfg   = wd & 16'hffff;
                2: r_xc    = wd & ((1 << CW) - 1);
                3: r_xm    = wd & AMSK;
                4: r_yc    = wd & ((1 << CW) - 1);
                5: r_ym    = wd & AMSK;
                default: ;
            endcase
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model.
    task automatic compare();
        chk(int'(cur_addr), m_addr, "R3,R4,R6 address");
        chk(int'(cur_xcnt), m_x, "R2,R3,R4 X count");
        chk(int'(cur_ycnt), m_y, "R2,R4,R6 Y count");
        chk(int'(elem_req), m_run, "R5,R11 request");
        chk(int'(status), (r_cfg[0] << 3) | ((m_run != 0) << 2) | (m_err << 1) | m_irq,
            "R7,R9,R10 status");
        chk(int'(data_irq), m_irq, "R7,R8 data_irq");
    endtask

    function automatic logic pick_ack();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
        case (ack_mode)
            0: return 1'b1;
            1: return cyc[0];
            2: return lfsr[0] | lfsr[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic tick();
        elem_ack = pick_ack();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int sel, input int data);
        reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = data;
        ack_mode = 3;
        tick();
        reg_we = 1'b0;
    endtask

    // Run until n elements are accepted.
    task automatic run_elems(input int n, input int mode);
        int got = 0;
        ack_mode = mode;
        while (got < n) begin
            elem_ack = pick_ack();
            if (elem_ack && elem_req) got++;
            @(posedge clk);
            @(negedge clk);
            compare();
        end
        ack_mode = 3;
    endtask

    task automatic setup(input int st, input int xc, input int xm, input int yc, input int ym);
        wr(0, st); wr(2, xc); wr(3, xm); wr(4, yc); wr(5, ym);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        ack_mode = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        chk(int'(status), 0, "R10 reset status");
        chk(int'(elem_req), 0, "R10 reset request");

        // Auto-buffer, per-row interrupt, 2x512 16-bit.
        setup(32'h01000, 512, 2, 2, 2);
        wr(1, 32'h10D7);
        chk(int'(elem_wnr), 1, "R1 0x10D7 direction");
        chk(int'(elem_size), 1, "R1 0x10D7 width");
        chk(int'(status), 4'b1100, "R2 running after start");
        chk(int'(cur_addr), 32'h01000, "R2 start address");
        chk(int'(cur_xcnt), 512, "R2 X count load");
        chk(int'(cur_ycnt), 2, "R2 Y count load");
        run_elems(512, 0);
        chk(int'(cur_addr), 32'h01400, "R4 second row start");
        chk(int'(cur_ycnt), 1, "R4 Y count decremented");
        chk(int'(data_irq), 1, "R7 per-row interrupt");
        wr(6, 1);
        chk(int'(data_irq), 0, "R8 W1C clear");
        chk(int'(elem_req), 1, "R8 clear keeps running");
        run_elems(512, 1);
        chk(int'(cur_addr), 32'h01000, "R6 auto-buffer reload");
        chk(int'(cur_ycnt), 2, "R6 Y count reload");
        chk(int'(elem_req), 1, "R6 continues");
        // Hold with no acknowledge.
        repeat (4) tick();
        chk(int'(cur_addr), 32'h01000, "R12 hold without ack");
        wr(1, 0);
        chk(int'(elem_req), 0, "R11 halt");
        wr(6, 1);

        // Auto-buffer, no interrupt, 4x16 32-bit packets.
        setup(32'h02000, 16, 4, 4, 4);
        wr(1, 32'h101B);
        chk(int'(elem_size), 2, "R1 0x101B width");
        chk(int'(elem_wnr), 1, "R1 0x101B direction");
        run_elems(48, 2);
        chk(int'(cur_addr), 32'h020C0, "R4 fourth packet start");
        run_elems(16, 2);
        chk(int'(cur_addr), 32'h02000, "R6 packets wrap");
        chk(int'(data_irq), 0, "R7 interrupt disabled");
        run_elems(7, 2);
        wr(1, 0);

        // 1D stop, backwards, end-of-buffer interrupt, read direction.
        setup(32'h00010, 5, 32'hFFFFD, 0, 0);
        wr(1, 32'h0081);
        chk(int'(elem_wnr), 0, "R1 read direction");
        chk(int'(cur_ycnt), 1, "R2 1D Y count is one");
        run_elems(4, 1);
        chk(int'(cur_addr), 32'h00004, "R3 negative X step");
        chk(int'(data_irq), 0, "R7 no interrupt before buffer end");
        run_elems(1, 1);
        chk(int'(status), 4'b1001, "R5 stopped, enabled, interrupt");
        chk(int'(elem_req), 0, "R5 request dropped");
        wr(6, 1);

        // 2D stop, negative Y step wrapping below zero, per-row irq off.
        setup(32'h00008, 3, 4, 3, 32'hFFFE0);
        wr(1, 32'h0091);
        run_elems(3, 2);
        chk(int'(cur_addr), 32'hFFFF0, "R4 negative Y step wrap");
        chk(int'(data_irq), 0, "R7 buffer-end timing only");
        run_elems(6, 0);
        chk(int'(data_irq), 1, "R7 buffer-end interrupt");
        chk(int'(elem_req), 0, "R5 stop after 2D buffer");
        wr(6, 1);

        // Zero counts.
        setup(32'h00100, 0, 1, 2, 1);
        wr(1, 32'h0001);
        chk(int'(status), 4'b1010, "R9 zero X count error");
        wr(2, 4); wr(4, 0);
        wr(1, 32'h0011);
        chk(int'(elem_req), 0, "R9 zero Y count in 2D");
        wr(6, 2);
        chk(int'(status[1]), 0, "R9 error cleared");
        wr(1, 32'h0001);
        chk(int'(elem_req), 1, "R9 zero Y count ignored in 1D");
        run_elems(2, 0);
        wr(1, 0);
        chk(int'(status), 0, "R10 disabled");
        repeat (3) tick();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule